// File: doc/BRIEF.md
# Write-Only Two-Wire Bus Master with Self Clock Stretching

This block is a bus master for a two-wire serial bus (I2C-style signalling) that only performs write transfers. A processor-side interface gives it a slave address, a transmit byte register and three strobes: start, stop and byte write. A start strobe sends a start condition, then the 7-bit address with a write direction bit, and then one data byte after another from the transmit register. Each byte is followed by an acknowledge clock in which the slave answers.

The transmit register holds one byte. It stays occupied until that byte has been sent and acknowledged, at which point the master pulses a byte-sent event. If the master is ready for the next byte and software has not supplied one, the master keeps SCL pulled low until a byte arrives. A NACK from the slave raises an error pulse and ends the transfer with a stop condition. A stop strobe from software ends the transfer after the byte in progress.

Both bus lines are modelled as open-drain pull-down enables. The SDA level is sampled back for the acknowledge bit. A divider register, writable only while the block is disabled, sets the length of every SCL high and low phase.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset, both pull-down enables (`scl_oe_o`, `sda_oe_o`) are 0, and `busy_o`, `sent_o` and `err_o` are 0.
- R2: A start strobe while enabled and idle produces a start condition: SDA is pulled low while SCL is released. The first byte on the bus is then the 7-bit address followed by a direction bit of 0 (write is 0).
- R3: Outside the start and stop conditions, SDA changes only while SCL is low. Exactly one start and one stop condition appear per transfer.
- R4: In the ninth clock of every byte the master releases SDA and samples the line at the end of the SCL high phase: 0 is ACK, 1 is NACK. On an ACK the transfer goes on.
- R5: After the address is acknowledged, each byte from the transmit register goes out MSB first, followed by its acknowledge clock.
- R6: `sent_o` pulses high for exactly one clock after the acknowledge bit of each data byte has been sampled. It never pulses for the address byte.
- R7: A byte write is accepted only while the transmit register is empty and the block is enabled. The register stays occupied from the write until that byte's `sent_o` pulse, and writes in that window are ignored. The register is emptied when a transfer ends.
- R8: When the master is ready for a data byte and the transmit register is empty, it holds SCL low with SDA released until a byte is written, and then continues with that byte.
- R9: A NACK to the address or to a data byte gives a one-clock `err_o` pulse followed by a stop condition. A NACKed data byte still produces its `sent_o` pulse.
- R10: A stop strobe during a transfer takes effect after the current byte's acknowledge clock, or at once if the master is stretching SCL. The stop is SDA low with SCL low, then SCL released, then SDA released. The lines stay released and `busy_o` drops.
- R11: Every SCL high and low phase of a bit lasts N system clocks, where N is the divider value (0 counts as 1). A divider write takes effect only while `en_i` is 0 and is ignored while enabled.
- R12: With `en_i` at 0, start strobes are ignored, and dropping `en_i` during a transfer returns the block to idle with both lines released on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| cfg_div_we_i | input | 1 | Divider write strobe (honoured only while disabled) |
| cfg_div_i | input | DIV_W | Divider value: system clocks per SCL phase |
| addr_i | input | 7 | Slave address, captured at the start strobe |
| start_i | input | 1 | Start-transmit strobe |
| stop_i | input | 1 | Stop strobe |
| txd_we_i | input | 1 | Transmit byte write strobe |
| txd_i | input | 8 | Transmit byte |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Transfer in progress |
| sent_o | output | 1 | One-clock byte-sent event |
| err_o | output | 1 | One-clock NACK error event |

## Verification
A bit counter off by one shows within one byte time: the acknowledge clock moves, the byte seen by the slave model is shifted, and the start and stop counts go wrong. A wrong occupancy flag on the transmit register shows at the next byte boundary. Either the stretch is missing and a stale byte is sent again, or the stretch never ends. Both cases show up as a received byte that differs from the expected one, or as a missing `sent_o`. A lost stop request or a NACK treated as an ACK shows as `busy_o` staying high past the expected end, or as an extra data byte after the error pulse.

// File: rtl/i2c_wm_pkg.sv
package i2c_wm_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int BIT_CW = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BLO,
        ST_BHI,
        ST_HOLD,
        ST_PLO,
        ST_PHI,
        ST_PEND
    } wm_state_e;

    typedef struct packed {
        wm_state_e          state;
        logic [BYTE_W-1:0]  shift;
        logic [BIT_CW-1:0]  bitn;
        logic               is_data;
        logic               stop_pend;
        logic               sent;
        logic               err;
    } wm_regs_t;

    localparam wm_regs_t REGS_RST = '{
        state:     ST_IDLE,
        shift:     '0,
        bitn:      '0,
        is_data:   1'b0,
        stop_pend: 1'b0,
        sent:      1'b0,
        err:       1'b0
    };

endpackage

// File: rtl/i2c_wm_cfg.sv
module i2c_wm_cfg #(
    parameter int          DIV_W   = 8,
    parameter int unsigned DIV_RST = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [DIV_W-1:0] wdata_i,
    output logic [DIV_W-1:0] div_o
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (we_i && !en_i) begin
            div_d = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= DIV_W'(DIV_RST);
        end else begin
            div_q <= div_d;
        end
    end

    assign div_o = (div_q == '0) ? DIV_ONE : div_q;

endmodule

// File: rtl/i2c_wm_tick.sv
module i2c_wm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == div_i - 1'b1);

    always_comb begin
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2c_wm_txbuf.sv
module i2c_wm_txbuf #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         accept_i,
    input  logic         we_i,
    input  logic [W-1:0] data_i,
    input  logic         clear_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);

    logic         full_d, full_q;
    logic [W-1:0] data_d, data_q;

    always_comb begin
        full_d = full_q;
        data_d = data_q;
        if (clear_i) begin
            full_d = 1'b0;
        end else if (we_i && accept_i && !full_q) begin
            full_d = 1'b1;
            data_d = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            full_q <= full_d;
            data_q <= data_d;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
    import i2c_wm_pkg::*;
#(
    parameter int          DIV_W   = 8,
    parameter int unsigned DIV_RST = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              cfg_div_we_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              txd_we_i,
    input  logic [BYTE_W-1:0] txd_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              busy_o,
    output logic              sent_o,
    output logic              err_o
);

    localparam logic [BIT_CW-1:0] ACK_SLOT = BIT_CW'(BYTE_W);

    wm_regs_t          r_d, r_q;
    logic [DIV_W-1:0]  div_eff;
    logic              tick;
    logic              run;
    logic              buf_full;
    logic [BYTE_W-1:0] buf_data;
    logic              byte_done;
    logic              xfer_end;
    logic              in_bit;

    i2c_wm_cfg #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .we_i    (cfg_div_we_i),
        .wdata_i (cfg_div_i),
        .div_o   (div_eff)
    );

    i2c_wm_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .div_i  (div_eff),
        .tick_o (tick)
    );

    i2c_wm_txbuf #(
        .W (BYTE_W)
    ) u_txbuf (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .accept_i (en_i),
        .we_i     (txd_we_i),
        .data_i   (txd_i),
        .clear_i  (byte_done || xfer_end),
        .full_o   (buf_full),
        .data_o   (buf_data)
    );

    assign run = (r_q.state != ST_IDLE) && (r_q.state != ST_HOLD);

    always_comb begin
        r_d       = r_q;
        r_d.sent  = 1'b0;
        r_d.err   = 1'b0;
        byte_done = 1'b0;
        xfer_end  = 1'b0;

        if (stop_i && r_q.state != ST_IDLE) begin
            r_d.stop_pend = 1'b1;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                r_d.stop_pend = 1'b0;
                if (start_i) begin
                    r_d.state   = ST_START;
                    r_d.shift   = {addr_i, 1'b0};
                    r_d.bitn    = '0;
                    r_d.is_data = 1'b0;
                end
            end
            ST_START: begin
                if (tick) r_d.state = ST_BLO;
            end
            ST_BLO: begin
                if (tick) r_d.state = ST_BHI;
            end
            ST_BHI: begin
                if (tick) begin
                    if (r_q.bitn != ACK_SLOT) begin
                        r_d.shift = {r_q.shift[BYTE_W-2:0], 1'b0};
                        r_d.bitn  = r_q.bitn + 1'b1;
                        r_d.state = ST_BLO;
                    end else begin
                        if (r_q.is_data) begin
                            r_d.sent  = 1'b1;
                            byte_done = 1'b1;
                        end
                        if (sda_i) begin
                            r_d.err   = 1'b1;
                            r_d.state = ST_PLO;
                        end else if (r_d.stop_pend) begin
                            r_d.state = ST_PLO;
                        end else begin
                            r_d.state = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (r_d.stop_pend) begin
                    r_d.state = ST_PLO;
                end else if (buf_full) begin
                    r_d.shift   = buf_data;
                    r_d.bitn    = '0;
                    r_d.is_data = 1'b1;
                    r_d.state   = ST_BLO;
                end
            end
            ST_PLO: begin
                if (tick) r_d.state = ST_PHI;
            end
            ST_PHI: begin
                if (tick) r_d.state = ST_PEND;
            end
            ST_PEND: begin
                if (tick) begin
                    r_d.state = ST_IDLE;
                    xfer_end  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (!en_i) begin
            r_d      = REGS_RST;
            xfer_end = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_bit   = ((r_q.state == ST_BLO) || (r_q.state == ST_BHI)) && (r_q.bitn != ACK_SLOT);
    assign scl_oe_o = (r_q.state == ST_BLO) || (r_q.state == ST_HOLD) || (r_q.state == ST_PLO);
    assign sda_oe_o = (r_q.state == ST_START) || (r_q.state == ST_PLO) || (r_q.state == ST_PHI)
                      || (in_bit && !r_q.shift[BYTE_W-1]);
    assign busy_o   = (r_q.state != ST_IDLE);
    assign sent_o   = r_q.sent;
    assign err_o    = r_q.err;

endmodule

// File: rtl/i2c_wr_master_chk.sv
module i2c_wr_master_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             busy,
    input logic             sent,
    input logic             err,
    input logic             buf_full,
    input logic [DIV_W-1:0] div_eff
);

    a_r6_sent_single: assert property (@(posedge clk) disable iff (!rst_n)
        sent |=> !sent);

    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r9_err_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (busy && scl_oe && sda_oe));

    a_r7_sent_frees_reg: assert property (@(posedge clk) disable iff (!rst_n)
        sent |-> !buf_full);

    a_r3_sda_fall_high_is_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> $rose(busy));

    a_r11_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(div_eff));

    a_r12_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !scl_oe && !sda_oe));

endmodule

bind i2c_wr_master i2c_wr_master_chk #(
    .DIV_W (DIV_W)
) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .en       (en_i),
    .scl_oe   (scl_oe_o),
    .sda_oe   (sda_oe_o),
    .busy     (busy_o),
    .sent     (sent_o),
    .err      (err_o),
    .buf_full (buf_full),
    .div_eff  (div_eff)
);

// File: tb/tb_i2c_wr_master.sv
module tb_i2c_wr_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       div_we = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic [6:0] addr = 7'd0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       txd_we = 1'b0;
    logic [7:0] txd = 8'd0;
    logic       slv_pull = 1'b0;
    logic       scl_oe, sda_oe, busy, sent, err;
    logic       scl_line, sda_line;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slv_pull);

    always #4 clk = ~clk;

    i2c_wr_master dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .en_i         (en),
        .cfg_div_we_i (div_we),
        .cfg_div_i    (div_val),
        .addr_i       (addr),
        .start_i      (start),
        .stop_i       (stop),
        .txd_we_i     (txd_we),
        .txd_i        (txd),
        .sda_i        (sda_line),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .busy_o       (busy),
        .sent_o       (sent),
        .err_o        (err)
    );

    typedef struct packed {
        logic [7:0] div;
        logic [6:0] addr;
        logic [1:0] nbytes;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [2:0] nack_at;   // rx index that gets NACK, 7 = none
        logic [1:0] exp_sent;
        logic       exp_err;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'd3, 7'h50, 2'd1, 8'hA5, 8'h00, 8'h00, 3'd7, 2'd1, 1'b0},
        '{8'd2, 7'h2A, 2'd3, 8'h3C, 8'hC3, 8'h01, 3'd7, 2'd3, 1'b0},
        '{8'd1, 7'h7F, 2'd2, 8'hFF, 8'h00, 8'h00, 3'd0, 2'd0, 1'b1},
        '{8'd4, 7'h01, 2'd3, 8'h80, 8'h7E, 8'h55, 3'd2, 2'd2, 1'b1},
        '{8'd5, 7'h00, 2'd2, 8'h12, 8'h34, 8'h00, 3'd7, 2'd2, 1'b0}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // slave model and event counters (only this process writes them)
    logic [7:0] rx [8];
    int rx_n = 0;
    int starts = 0;
    int stops = 0;
    int sent_cnt = 0;
    int err_cnt = 0;
    int nack_at = 7;

    initial begin
        int s_bits;
        logic [7:0] s_sh;
        logic p_scl, p_sda, c_scl, c_sda;
        s_bits = 0;
        s_sh = 8'h00;
        p_scl = 1'b1;
        p_sda = 1'b1;
        forever begin
            @(negedge clk);
            c_scl = scl_line;
            c_sda = sda_line;
            if (rst_n) begin
                if (p_scl && c_scl && p_sda && !c_sda) begin
                    starts++;
                    s_bits = 0;
                    rx_n = 0;
                end else if (p_scl && c_scl && !p_sda && c_sda) begin
                    stops++;
                    s_bits = 0;
                    slv_pull = 1'b0;
                end else if (!p_scl && c_scl) begin
                    if (s_bits < 8) s_sh = {s_sh[6:0], c_sda};
                    s_bits++;
                end else if (p_scl && !c_scl) begin
                    if (s_bits == 8) begin
                        if (rx_n < 8) rx[rx_n] = s_sh;
                        slv_pull = (rx_n != nack_at);
                        rx_n++;
                    end else if (s_bits == 9) begin
                        slv_pull = 1'b0;
                        s_bits = 0;
                    end
                end
                if (sent) sent_cnt++;
                if (err) err_cnt++;
            end
            p_scl = c_scl;
            p_sda = c_sda;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        txd = b;
        txd_we = 1'b1;
        @(negedge clk);
        txd_we = 1'b0;
    endtask

    task automatic pulse_start(input logic [6:0] a);
        @(negedge clk);
        addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic pulse_div(input logic [7:0] d);
        @(negedge clk);
        div_val = d;
        div_we = 1'b1;
        @(negedge clk);
        div_we = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] d);
        @(negedge clk);
        en = 1'b0;
        pulse_div(d);
        @(negedge clk);
        en = 1'b1;
    endtask

    // length of the first SCL high phase after SCL has been low
    task automatic measure_high(output int len);
        len = 0;
        while (!scl_oe) @(negedge clk);
        while (scl_oe) @(negedge clk);
        while (!scl_oe) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        tick(2);
    endtask

    function automatic logic [7:0] vbyte(input vec_t v, input int k);
        case (k)
            0: return v.b0;
            1: return v.b1;
            default: return v.b2;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int hi, s0, e0, st0, sp0, exp_rx, viol;
        tick(5);
        // R1: reset state
        check("R1 scl_oe at reset", int'(scl_oe), 0);
        check("R1 sda_oe at reset", int'(sda_oe), 0);
        check("R1 busy at reset", int'(busy), 0);
        check("R1 events at reset", int'({sent, err}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(3);
        check("R1 lines after reset release", int'({scl_oe, sda_oe, busy}), 0);

        // table of transfers
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            set_div(v.div);
            nack_at = int'(v.nack_at);
            s0 = sent_cnt; e0 = err_cnt; st0 = starts; sp0 = stops;
            write_byte(v.b0);
            pulse_start(v.addr);
            measure_high(hi);
            check("R11 high phase = divider", hi, int'(v.div));
            for (int k = 1; k < int'(v.nbytes); k++) begin
                while (busy && (sent_cnt - s0) < k) @(negedge clk);
                if (!busy || err_cnt != e0) break;
                write_byte(vbyte(v, k));
            end
            while (busy && (sent_cnt - s0) < int'(v.nbytes) && err_cnt == e0) @(negedge clk);
            if (busy && err_cnt == e0) pulse_stop();
            wait_idle();
            exp_rx = (v.nack_at == 3'd7) ? int'(v.nbytes) + 1 : int'(v.nack_at) + 1;
            check("R2 address byte with write bit 0", int'(rx[0]), int'({v.addr, 1'b0}));
            check("R4/R5 bytes seen by slave", rx_n, exp_rx);
            for (int k = 1; k < exp_rx; k++)
                check("R5 data byte MSB first", int'(rx[k]), int'(vbyte(v, k - 1)));
            check("R6 byte-sent events", sent_cnt - s0, int'(v.exp_sent));
            check("R9 error events", err_cnt - e0, int'(v.exp_err));
            check("R3 one start per transfer", starts - st0, 1);
            check("R3 one stop per transfer", stops - sp0, 1);
            check("R10 lines released at end", int'({scl_oe, sda_oe, busy}), 0);
        end
        nack_at = 7;

        // R8 stretching, R7 write ignored while occupied
        set_div(8'd2);
        s0 = sent_cnt; sp0 = stops;
        write_byte(8'hAA);
        pulse_start(7'h11);
        write_byte(8'hEE);
        while (busy && (sent_cnt - s0) < 1) @(negedge clk);
        viol = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!(scl_oe && !sda_oe && busy)) viol++;
        end
        check("R8 SCL held low while register empty", viol, 0);
        write_byte(8'h5B);
        while (busy && (sent_cnt - s0) < 2) @(negedge clk);
        pulse_stop();
        wait_idle();
        check("R7 write while occupied ignored", int'(rx[1]), 8'hAA);
        check("R8 byte after stretch sent", int'(rx[2]), 8'h5B);
        check("R8 bytes in stretched transfer", rx_n, 3);
        check("R10 stop from stretch", stops - sp0, 1);

        // R10 early stop: only the address goes out, then R7 flush
        s0 = sent_cnt; sp0 = stops;
        write_byte(8'h77);
        pulse_start(7'h22);
        pulse_stop();
        wait_idle();
        check("R10 early stop after address ack", rx_n, 1);
        check("R10 no data byte after early stop", sent_cnt - s0, 0);
        check("R10 stop condition seen", stops - sp0, 1);
        s0 = sent_cnt;
        write_byte(8'h99);
        pulse_start(7'h22);
        while (busy && (sent_cnt - s0) < 1) @(negedge clk);
        pulse_stop();
        wait_idle();
        check("R7 register emptied at transfer end", int'(rx[1]), 8'h99);

        // R11 divider write ignored while enabled; 0 acts as 1
        pulse_div(8'd9);
        s0 = sent_cnt;
        write_byte(8'h3C);
        pulse_start(7'h33);
        measure_high(hi);
        check("R11 divider write while enabled ignored", hi, 2);
        while (busy && (sent_cnt - s0) < 1) @(negedge clk);
        pulse_stop();
        wait_idle();
        set_div(8'd0);
        write_byte(8'h3C);
        pulse_start(7'h33);
        measure_high(hi);
        check("R11 divider 0 acts as 1", hi, 1);
        s0 = sent_cnt;
        while (busy && (sent_cnt - s0) < 1) @(negedge clk);
        pulse_stop();
        wait_idle();

        // R12 disabled start ignored, disable mid-transfer
        set_div(8'd3);
        @(negedge clk);
        en = 1'b0;
        pulse_start(7'h44);
        tick(3);
        check("R12 start ignored while disabled", int'({busy, scl_oe, sda_oe}), 0);
        @(negedge clk);
        en = 1'b1;
        write_byte(8'h0F);
        pulse_start(7'h44);
        tick(10);
        check("R12 busy before disable", int'(busy), 1);
        en = 1'b0;
        @(negedge clk);
        check("R12 disable returns to idle", int'({busy, scl_oe, sda_oe}), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule